// File: doc/BRIEF.md
# Region-Partitioned Page Translation Cache

This block turns a 30-bit logical byte address into a 26-bit physical word address using a small, fully associative cache of page descriptors. The logical space is cut into four regions. Three of them belong to the running process: code, heap and stack. The fourth belongs to the operating system. Each region has its own page-count limit, so the regions can grow independently. Pages are 4 KB and a region can span up to 256 MB, which gives a 16-bit in-region page number.

The cache holds 16 descriptors. Each descriptor is tagged by region and page number and carries a physical frame number plus rights bits. A lookup that hits answers one clock after the request, together with any page or protection fault. Descriptors are not fetched from memory by the block. On a miss, supervising software reads the tables itself and writes the descriptor through the fill port. A flush input empties the cache, for example on a context switch.

Top module: `xlate_cache`

## Requirements
- R1: After synchronous reset every output is 0, the cache holds no descriptor, the fill pointer is at slot 0 and every region limit is 16'hFFFF.
- R2: The logical address splits as region = addr[29:28], page = addr[27:12], byte offset = addr[11:0]. On a clean hit the physical address is {frame[15:0], addr[11:2]}. On any other outcome the physical address is 0.
- R3: The response to a request sampled at a clock edge is registered at that edge. `rsp_valid` follows `req_valid` with one cycle of delay, and all flags are 0 when no request was sampled.
- R4: A request within its region limit that matches no stored descriptor gives `rsp_miss`=1 and `rsp_hit`=0.
- R5: A request whose page is greater than the limit of its region gives `rsp_limit_fault`=1 with hit and miss both 0, whatever the cache holds. A page equal to the limit is allowed.
- R6: The rights field is bit0 present, bit1 read, bit2 write, bit3 execute, bit4 kernel-only. A hit on a descriptor with present=0 gives `rsp_hit`=1 and `rsp_page_fault`=1.
- R7: Access kind 0 is read and needs the read bit. Kind 1 is write and needs the write bit. Kind 2 is execute and needs the execute bit. Kind 3 is treated as read. A present descriptor that lacks the needed right, or that is kernel-only while `req_kernel`=0, gives `rsp_hit`=1 and `rsp_prot_fault`=1. A page fault takes precedence over a protection fault.
- R8: A fill whose region and page already sit in the cache overwrites that slot and leaves the fill pointer unchanged. Any other fill writes the slot under the pointer, and the pointer then advances by one, wrapping from 15 to 0. The 17th distinct fill therefore evicts the first.
- R9: Flush empties every slot and returns the fill pointer to 0 at the next edge. A fill in the same cycle as a flush is dropped.
- R10: The tag includes the region, so the same page number in a different region does not hit.
- R11: A limit write takes effect at the next edge. A request in the same cycle uses the old limit. A lookup in the same cycle as a fill or flush sees the cache contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 30 | Logical byte address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_kernel | input | 1 | Requester runs in kernel mode |
| fill_valid | input | 1 | Write a descriptor into the cache |
| fill_region | input | 2 | Region of the descriptor |
| fill_vpn | input | 16 | Page number of the descriptor |
| fill_frame | input | 16 | Physical frame number |
| fill_rights | input | 5 | Rights bits (R6 encoding) |
| flush | input | 1 | Empty the cache |
| lim_wr | input | 1 | Write a region limit |
| lim_region | input | 2 | Region whose limit is written |
| lim_value | input | 16 | Highest allowed page number |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 26 | Physical word address |
| rsp_hit | output | 1 | A descriptor matched |
| rsp_miss | output | 1 | No descriptor matched |
| rsp_limit_fault | output | 1 | Page above region limit |
| rsp_page_fault | output | 1 | Matched descriptor not present |
| rsp_prot_fault | output | 1 | Rights violated |

## Verification
The bench targets the page equal to the limit. A design that compares with greater-or-equal faults there, and one that does not check the limit at all lets the page above through. It also issues lookups in the same cycle as a fill, a flush or a limit write. A design that forwards the new state answers those a cycle early. It refills a tag that is already cached and then issues 17 distinct fills. A design that allocates a second slot for the same tag, or that gets the pointer wrap wrong, evicts the wrong descriptor and later mismatches. Finally, it sends the same page number from another region, and it sends kernel-only and not-present descriptors under every access kind, to catch a tag without the region bits and a wrong fault precedence.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int REGION_W    = 2;
    localparam int VPN_W       = 16;
    localparam int OFF_W       = 12;
    localparam int FRAME_W     = 16;
    localparam int WORD_OFF_W  = OFF_W - 2;
    localparam int PADDR_W     = FRAME_W + WORD_OFF_W;
    localparam int LADDR_W     = REGION_W + VPN_W + OFF_W;
    localparam int NUM_REGIONS = 1 << REGION_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    // packed: first field is the MSB, so present sits at bit 0
    typedef struct packed {
        logic kern_only;
        logic can_exec;
        logic can_write;
        logic can_read;
        logic present;
    } rights_t;

    typedef struct packed {
        logic [REGION_W-1:0] region;
        logic [VPN_W-1:0]    vpn;
    } tag_t;

    typedef struct packed {
        logic                used;
        tag_t                tag;
        logic [FRAME_W-1:0]  frame;
        rights_t             rights;
    } slot_t;

    typedef struct packed {
        logic               valid;
        logic [PADDR_W-1:0] paddr;
        logic               hit;
        logic               miss;
        logic               limit_fault;
        logic               page_fault;
        logic               prot_fault;
    } rsp_t;

    function automatic logic access_allowed(rights_t r, acc_kind_e k, logic kern);
        logic need;
        case (k)
            ACC_WRITE: need = r.can_write;
            ACC_EXEC:  need = r.can_exec;
            default:   need = r.can_read;
        endcase
        return need && (kern || !r.kern_only);
    endfunction
endpackage

// File: rtl/xlt_limit_bank.sv
module xlt_limit_bank
    import xlt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REGION_W-1:0] wr_region,
    input  logic [VPN_W-1:0]    wr_value,
    input  logic [REGION_W-1:0] rd_region,
    output logic [VPN_W-1:0]    rd_limit
);
    logic [VPN_W-1:0] limit_q [NUM_REGIONS];

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lim
            always_ff @(posedge clk) begin
                if (rst)
                    limit_q[g] <= '1;
                else if (wr_en && wr_region == REGION_W'(g))
                    limit_q[g] <= wr_value;
            end
        end
    endgenerate

    assign rd_limit = limit_q[rd_region];
endmodule

// File: rtl/xlt_tag_store.sv
module xlt_tag_store
    import xlt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               fill_en,
    input  tag_t               fill_tag,
    input  logic [FRAME_W-1:0] fill_frame,
    input  rights_t            fill_rights,
    input  tag_t               look_tag,
    output logic               look_hit,
    output logic [FRAME_W-1:0] look_frame,
    output rights_t            look_rights
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    slot_t                  slots [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] look_match;
    logic [NUM_ENTRIES-1:0] fill_match;
    logic [IDX_W-1:0]       look_idx;
    logic [IDX_W-1:0]       fill_hit_idx;
    logic [IDX_W-1:0]       fill_idx;
    logic [IDX_W-1:0]       rr_ptr;

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            assign look_match[g] = slots[g].used && (slots[g].tag == look_tag);
            assign fill_match[g] = slots[g].used && (slots[g].tag == fill_tag);
        end
    endgenerate

    always_comb begin
        look_idx     = '0;
        fill_hit_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (look_match[i]) look_idx     = IDX_W'(i);
            if (fill_match[i]) fill_hit_idx = IDX_W'(i);
        end
    end

    assign look_hit    = |look_match;
    assign look_frame  = slots[look_idx].frame;
    assign look_rights = slots[look_idx].rights;
    assign fill_idx    = (|fill_match) ? fill_hit_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) slots[i] <= '0;
            rr_ptr <= '0;
        end else if (fill_en) begin
            slots[fill_idx] <= '{used: 1'b1, tag: fill_tag, frame: fill_frame, rights: fill_rights};
            if (!(|fill_match))
                rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xlt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [LADDR_W-1:0]     req_addr,
    input  logic [1:0]             req_kind,
    input  logic                   req_kernel,
    input  logic                   fill_valid,
    input  logic [REGION_W-1:0]    fill_region,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [FRAME_W-1:0]     fill_frame,
    input  logic [4:0]             fill_rights,
    input  logic                   flush,
    input  logic                   lim_wr,
    input  logic [REGION_W-1:0]    lim_region,
    input  logic [VPN_W-1:0]       lim_value,
    output logic                   rsp_valid,
    output logic [PADDR_W-1:0]     rsp_paddr,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic                   rsp_limit_fault,
    output logic                   rsp_page_fault,
    output logic                   rsp_prot_fault
);
    tag_t                req_tag;
    logic [VPN_W-1:0]    region_limit;
    logic                look_hit;
    logic [FRAME_W-1:0]  look_frame;
    rights_t             look_rights;
    rsp_t                rsp_d, rsp_q;

    assign req_tag.region = req_addr[LADDR_W-1 -: REGION_W];
    assign req_tag.vpn    = req_addr[OFF_W +: VPN_W];

    xlt_limit_bank u_limits (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (lim_wr),
        .wr_region (lim_region),
        .wr_value  (lim_value),
        .rd_region (req_tag.region),
        .rd_limit  (region_limit)
    );

    xlt_tag_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .fill_en     (fill_valid),
        .fill_tag    ('{region: fill_region, vpn: fill_vpn}),
        .fill_frame  (fill_frame),
        .fill_rights (rights_t'(fill_rights)),
        .look_tag    (req_tag),
        .look_hit    (look_hit),
        .look_frame  (look_frame),
        .look_rights (look_rights)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (req_tag.vpn > region_limit) begin
                rsp_d.limit_fault = 1'b1;
            end else if (!look_hit) begin
                rsp_d.miss = 1'b1;
            end else begin
                rsp_d.hit = 1'b1;
                if (!look_rights.present)
                    rsp_d.page_fault = 1'b1;
                else if (!access_allowed(look_rights, acc_kind_e'(req_kind), req_kernel))
                    rsp_d.prot_fault = 1'b1;
                else
                    rsp_d.paddr = {look_frame, req_addr[OFF_W-1:2]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_paddr       = rsp_q.paddr;
    assign rsp_hit         = rsp_q.hit;
    assign rsp_miss        = rsp_q.miss;
    assign rsp_limit_fault = rsp_q.limit_fault;
    assign rsp_page_fault  = rsp_q.page_fault;
    assign rsp_prot_fault  = rsp_q.prot_fault;
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker
    import xlt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               flush,
    input logic               rsp_valid,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_limit_fault,
    input logic               rsp_page_fault,
    input logic               rsp_prot_fault
);
    logic flush_q;
    always_ff @(posedge clk) begin
        if (rst) flush_q <= 1'b0;
        else     flush_q <= flush;
    end

    assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_limit_fault));

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_hit, rsp_miss, rsp_limit_fault}));

    assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_page_fault || rsp_prot_fault) |-> (rsp_hit && !(rsp_page_fault && rsp_prot_fault)));

    assert_no_addr_on_fault_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss || rsp_limit_fault || rsp_page_fault || rsp_prot_fault) |-> (rsp_paddr == '0));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        (flush_q && req_valid) |=> !rsp_hit);
endmodule

bind xlate_cache xlt_checker u_xlt_checker (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .flush           (flush),
    .rsp_valid       (rsp_valid),
    .rsp_paddr       (rsp_paddr),
    .rsp_hit         (rsp_hit),
    .rsp_miss        (rsp_miss),
    .rsp_limit_fault (rsp_limit_fault),
    .rsp_page_fault  (rsp_page_fault),
    .rsp_prot_fault  (rsp_prot_fault)
);

// File: tb/xlate_cache_bench.sv
module xlate_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0;
    logic [29:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_kernel = 0;
    logic        fill_valid = 0;
    logic [1:0]  fill_region = '0;
    logic [15:0] fill_vpn = '0;
    logic [15:0] fill_frame = '0;
    logic [4:0]  fill_rights = '0;
    logic        flush = 0;
    logic        lim_wr = 0;
    logic [1:0]  lim_region = '0;
    logic [15:0] lim_value = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_limit_fault, rsp_page_fault, rsp_prot_fault;
    logic [25:0] rsp_paddr;

    always #10 clk = ~clk;

    xlate_cache u_xlate_cache (.*);

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural reference model state
    bit          m_used   [16];
    logic [1:0]  m_region [16];
    logic [15:0] m_vpn    [16];
    logic [15:0] m_frame  [16];
    logic [4:0]  m_rights [16];
    int          m_ptr;
    logic [15:0] m_lim [4];
    logic [31:0] exp_vec;

    task automatic model_edge();
        int r, v, found;
        bit ok;
        logic [25:0] pa;
        logic [4:0] rt;
        exp_vec = '0;
        if (rst) begin
            for (int i = 0; i < 16; i++) m_used[i] = 0;
            m_ptr = 0;
            for (int i = 0; i < 4; i++) m_lim[i] = 16'hFFFF;
            return;
        end
        if (req_valid) begin
            r = int'(req_addr[29:28]);
            v = int'(req_addr[27:12]);
            found = -1;
            for (int i = 0; i < 16; i++)
                if (m_used[i] && int'(m_region[i]) == r && int'(m_vpn[i]) == v) found = i;
            exp_vec[31] = 1;
            if (v > int'(m_lim[r])) exp_vec[28] = 1;
            else if (found < 0) exp_vec[29] = 1;
            else begin
                exp_vec[30] = 1;
                rt = m_rights[found];
                case (req_kind)
                    2'd1: ok = rt[2];
                    2'd2: ok = rt[3];
                    default: ok = rt[1];
                endcase
                if (rt[4] && !req_kernel) ok = 0;
                pa = {m_frame[found], req_addr[11:2]};
                if (!rt[0]) exp_vec[27] = 1;
                else if (!ok) exp_vec[26] = 1;
                else exp_vec[25:0] = pa;
            end
        end
        if (flush) begin
            for (int i = 0; i < 16; i++) m_used[i] = 0;
            m_ptr = 0;
        end else if (fill_valid) begin
            found = -1;
            for (int i = 0; i < 16; i++)
                if (m_used[i] && m_region[i] == fill_region && m_vpn[i] == fill_vpn) found = i;
            if (found < 0) begin
                found = m_ptr;
                m_ptr = (m_ptr + 1) % 16;
            end
            m_used[found] = 1; m_region[found] = fill_region; m_vpn[found] = fill_vpn;
            m_frame[found] = fill_frame; m_rights[found] = fill_rights;
        end
        if (lim_wr) m_lim[lim_region] = lim_value;
    endtask

    task automatic step(string tag);
        logic [31:0] act;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        act = {rsp_valid, rsp_hit, rsp_miss, rsp_limit_fault, rsp_page_fault, rsp_prot_fault, rsp_paddr};
        compared++;
        if (act !== exp_vec) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h (v,hit,miss,lim,pf,prot,paddr)", tag, act, exp_vec);
        end
    endtask

    task automatic clr();
        req_valid = 0; fill_valid = 0; flush = 0; lim_wr = 0; req_kernel = 0; req_kind = 0;
    endtask

    task automatic req(input logic [1:0] r, input logic [15:0] v, input logic [11:0] off,
                       input logic [1:0] k, input logic kern, input string tag);
        clr();
        req_valid = 1; req_addr = {r, v, off}; req_kind = k; req_kernel = kern;
        step(tag);
    endtask

    task automatic fill(input logic [1:0] r, input logic [15:0] v, input logic [15:0] f,
                        input logic [4:0] rt, input string tag);
        clr();
        fill_valid = 1; fill_region = r; fill_vpn = v; fill_frame = f; fill_rights = rt;
        step(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        rst = 1;
        step("R1 reset held");
        step("R1 reset held");
        rst = 0;
        clr();
        step("R1 idle after reset");
        req(2'd1, 16'h0010, 12'h7FC, 0, 0, "R1 R4 empty cache misses");
        req(2'd3, 16'hFFFF, 12'h000, 0, 0, "R1 limit max after reset");

        fill(2'd1, 16'h0010, 16'hABCD, 5'b00111, "R8 first fill");
        req(2'd1, 16'h0010, 12'h7FC, 0, 0, "R2 R3 read hit address");
        req(2'd1, 16'h0010, 12'h003, 1, 0, "R7 write allowed");
        req(2'd1, 16'h0010, 12'h004, 2, 0, "R7 exec without right");
        req(2'd1, 16'h0010, 12'h008, 3, 0, "R7 kind 3 as read");
        req(2'd2, 16'h0010, 12'h008, 0, 0, "R10 other region misses");

        fill(2'd0, 16'h0002, 16'h1111, 5'b11110, "R6 not-present fill");
        req(2'd0, 16'h0002, 12'h000, 2, 1, "R6 page fault");
        req(2'd0, 16'h0002, 12'h000, 1, 0, "R6 page fault beats prot");
        fill(2'd3, 16'h0040, 16'h2222, 5'b11011, "R7 kernel-only fill");
        req(2'd3, 16'h0040, 12'hFFC, 0, 0, "R7 kernel-only from user");
        req(2'd3, 16'h0040, 12'hFFC, 0, 1, "R7 kernel-only from kernel");
        req(2'd3, 16'h0040, 12'hFFC, 1, 1, "R7 write without right");

        // same-cycle limit write and request uses old limit
        clr();
        lim_wr = 1; lim_region = 2'd1; lim_value = 16'h0010;
        req_valid = 1; req_addr = {2'd1, 16'h0011, 12'h0};
        step("R11 old limit same cycle");
        req(2'd1, 16'h0011, 12'h000, 0, 0, "R5 above limit");
        req(2'd1, 16'h0010, 12'h100, 0, 0, "R5 equal to limit hits");
        req(2'd1, 16'hFFFF, 12'h000, 0, 0, "R5 far above limit");

        // in-place refill, lookup in the same cycle sees old frame
        clr();
        fill_valid = 1; fill_region = 2'd1; fill_vpn = 16'h0010; fill_frame = 16'h5555; fill_rights = 5'b01111;
        req_valid = 1; req_addr = {2'd1, 16'h0010, 12'h010};
        step("R11 R8 lookup sees old frame");
        req(2'd1, 16'h0010, 12'h010, 2, 0, "R8 refill in place");

        // 17 distinct fills: round-robin wrap and eviction
        for (int i = 0; i < 17; i++)
            fill(2'd2, 16'(16'h0100 + i), 16'(16'h3000 + i), 5'b00011, "R8 sweep fill");
        for (int i = 0; i < 17; i++)
            req(2'd2, 16'(16'h0100 + i), 12'h020, 0, 0, "R8 eviction order");
        req(2'd1, 16'h0010, 12'h010, 0, 0, "R8 old entry evicted");

        // flush with concurrent fill and lookup
        clr();
        flush = 1; fill_valid = 1; fill_region = 2'd0; fill_vpn = 16'h0007; fill_frame = 16'h7777; fill_rights = 5'b00011;
        req_valid = 1; req_addr = {2'd2, 16'h0110, 12'h0};
        step("R9 R11 lookup during flush");
        req(2'd0, 16'h0007, 12'h000, 0, 0, "R9 fill dropped by flush");
        req(2'd2, 16'h0110, 12'h000, 0, 0, "R9 flushed entry gone");
        fill(2'd0, 16'h0007, 16'h7777, 5'b00011, "R9 pointer back at zero");
        req(2'd0, 16'h0007, 12'h000, 0, 0, "R9 fill after flush");

        // mixed traffic compared every clock
        for (int n = 0; n < 400; n++) begin
            clr();
            req_valid = ($urandom % 4) != 0;
            req_addr = {2'($urandom), 16'($urandom % 6), 12'($urandom)};
            req_kind = 2'($urandom);
            req_kernel = 1'($urandom);
            fill_valid = ($urandom % 3) == 0;
            fill_region = 2'($urandom);
            fill_vpn = 16'($urandom % 6);
            fill_frame = 16'($urandom);
            fill_rights = 5'($urandom);
            flush = ($urandom % 40) == 0;
            lim_wr = ($urandom % 25) == 0;
            lim_region = 2'($urandom);
            lim_value = 16'($urandom % 8);
            step("R3 R4 R5 R6 R7 mixed traffic");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule